// File: doc/BRIEF.md
# Snooping MOESI Coherence Controller

This block keeps one private cache coherent with its peers on a shared snooping bus. It holds a small, fully associative set of one-word lines, each tagged with its full address and tracked in one of the five stable MOESI states. It also tracks three transient states while a bus transaction it owns is in flight. A processor presents loads and stores and holds each request until the controller signals completion. A hit completes in the cycle it is presented. Any other request stalls while the controller wins the bus through a request/grant arbiter, issues a read, a read-for-ownership or an upgrade, and waits for the response.

Every transaction issued by another cache is presented on the snoop inputs. The controller reports whether it holds a copy of the snooped address. When it holds the only dirty copy it returns the data itself, so memory is bypassed. It also downgrades or drops its own copy as the snooped command requires. A dirty line chosen for eviction moves into a one-entry writeback buffer, and snoops that hit the buffer are answered from it. The bus is atomic: between this controller's grant and its response, no other transaction is snooped.

Command codes on the bus and snoop ports are: 1 read, 2 read-for-ownership, 3 upgrade, 4 writeback, 0 nothing.

Top module: `coh_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid. cpu_done, bus_req, bus_cmd, snp_shared and snp_supply are low, and the first access to any address misses.
- R2: A load to a line held in S, E, O or M raises cpu_done in the same cycle, with the line data on cpu_rdata and no bus request. At most one line ever matches an address.
- R3: A load miss raises bus_req, and on grant drives bus_cmd=1 with the request address. The fill enters E when rsp_shared is low with rsp_data_valid and S when it is high. The load then completes in the cycle after the fill.
- R4: A store miss issues bus_cmd=2 and holds the line in a transient state until both rsp_data_valid and rsp_acks_done have been seen, in either order or together. The line then becomes M, and the store completes in the next cycle.
- R5: A store to a line in S or O issues bus_cmd=3 and waits for rsp_acks_done. The line becomes M with its data kept, and the store completes in the next cycle.
- R6: A store to a line in E or M completes in the same cycle with no bus request, and leaves the line in M.
- R7: A snooped read (snp_cmd=1) raises snp_shared when a copy is held. An M or O line also raises snp_supply and places its data on snp_data. M moves to O, E moves to S, and S and O are unchanged. No bus command is issued.
- R8: A snooped read-for-ownership (2) or upgrade (3) that hits a line moves it to Invalid. An O or M line supplies its data on a snooped read-for-ownership.
- R9: If a snooped 2 or 3 invalidates the line of this controller's own pending upgrade before grant, the pending command becomes a read-for-ownership (2).
- R10: A miss takes the lowest-numbered Invalid line. When no line is Invalid it takes lines round-robin, starting at line 0. A victim in O or M is first written back with bus_cmd=4, its address on bus_addr and its data on bus_wdata, and only then is the fill issued.
- R11: A snoop that hits the pending writeback buffer raises snp_shared and supplies the buffered data for commands 1 and 2. A snooped 2 or 3 cancels the writeback, so bus_cmd=4 is never issued for it.
- R12: A processor request in a cycle with snp_valid high is stalled and has no effect in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until cpu_done |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | AW | Request address |
| cpu_wdata | input | DW | Store data |
| cpu_done | output | 1 | Request completes this cycle |
| cpu_stall | output | 1 | Request pending and not completing |
| cpu_rdata | output | DW | Load data, valid with cpu_done |
| bus_req | output | 1 | Request to the bus arbiter |
| bus_gnt | input | 1 | Grant from the arbiter |
| bus_cmd | output | 3 | Command issued in the granted cycle |
| bus_addr | output | AW | Address of the requested transaction |
| bus_wdata | output | DW | Writeback data |
| rsp_data_valid | input | 1 | Fill data present |
| rsp_data | input | DW | Fill data |
| rsp_shared | input | 1 | Another cache holds the line (with read fill) |
| rsp_acks_done | input | 1 | All invalidation acknowledgements collected |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 3 | Snooped command |
| snp_addr | input | AW | Snooped address |
| snp_shared | output | 1 | A copy of the snooped address is held |
| snp_supply | output | 1 | This cache supplies the data |
| snp_data | output | DW | Supplied data |

## Verification
The bench targets the ordering of fill data and acknowledgements for a read-for-ownership, in three variants: acks first, data first, and the converted command. A design that moved to M on the first event would let a store complete before the other sharers are gone. It also races a snooped upgrade against a pending upgrade. If the command were not converted, the bus would carry an upgrade for a line the cache no longer holds, and the cache would then write stale data. Snoops are placed while a dirty victim waits in the writeback buffer: a design that ignored the buffer would leave the requester with stale memory data, and one that kept the writeback after losing ownership would overwrite the new owner's line. Silent E-to-M, E-to-S and M-to-O transitions are each observed through later snoops, which would show missing or unexpected data supply.

// File: rtl/coh_snoop_ctrl.sv
module coh_snoop_ctrl #(
  parameter int AW    = 8,
  parameter int DW    = 8,
  parameter int LINES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic          cpu_done,
  output logic          cpu_stall,
  output logic [DW-1:0] cpu_rdata,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic [2:0]    bus_cmd,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          rsp_data_valid,
  input  logic [DW-1:0] rsp_data,
  input  logic          rsp_shared,
  input  logic          rsp_acks_done,
  input  logic          snp_valid,
  input  logic [2:0]    snp_cmd,
  input  logic [AW-1:0] snp_addr,
  output logic          snp_shared,
  output logic          snp_supply,
  output logic [DW-1:0] snp_data
);
  localparam int IW = (LINES > 1) ? $clog2(LINES) : 1;
  localparam logic [2:0] C_RD = 3'd1, C_RDX = 3'd2, C_UPG = 3'd3, C_WB = 3'd4;
  localparam logic [2:0] L_I = 3'd0, L_S = 3'd1, L_E = 3'd2, L_O = 3'd3, L_M = 3'd4;
  localparam logic [2:0] L_IS = 3'd5, L_IM = 3'd6, L_SM = 3'd7;
  localparam logic [1:0] F_IDLE = 2'd0, F_ARB = 2'd1, F_WAIT = 2'd2;

  logic [2:0]    st [LINES];
  logic [AW-1:0] tg [LINES];
  logic [DW-1:0] dt [LINES];
  logic [1:0]    fsm;
  logic [2:0]    pcmd;
  logic [IW-1:0] vidx, rr;
  logic          wb_v, gd, ga;
  logic [AW-1:0] wb_a;
  logic [DW-1:0] wb_d;

  function automatic logic stable(input logic [2:0] s);
    return (s == L_S) || (s == L_E) || (s == L_O) || (s == L_M);
  endfunction

  logic [LINES-1:0] cmatch, smatch, freev;
  logic [IW-1:0]    cidx, sidx, fidx;

  always_comb begin
    cmatch = '0; smatch = '0; freev = '0;
    cidx = '0; sidx = '0; fidx = '0;
    for (int i = LINES-1; i >= 0; i--) begin
      if (stable(st[i]) && tg[i] == cpu_addr) begin cmatch[i] = 1'b1; cidx = IW'(i); end
      if (stable(st[i]) && tg[i] == snp_addr) begin smatch[i] = 1'b1; sidx = IW'(i); end
      if (st[i] == L_I) begin freev[i] = 1'b1; fidx = IW'(i); end
    end
  end

  logic          chit, shit, wbhit, s_inv, idle_ok;
  logic [2:0]    cst, sst, cur_cmd;
  logic [IW-1:0] victim;

  assign chit    = |cmatch;
  assign shit    = snp_valid & (|smatch);
  assign cst     = st[cidx];
  assign sst     = st[sidx];
  assign wbhit   = snp_valid & wb_v & (wb_a == snp_addr);
  assign s_inv   = shit & ((snp_cmd == C_RDX) | (snp_cmd == C_UPG));
  assign victim  = (|freev) ? fidx : rr;
  assign idle_ok = (fsm == F_IDLE) & cpu_req & ~snp_valid;

  assign snp_shared = shit | wbhit;
  assign snp_supply = ((snp_cmd == C_RD) | (snp_cmd == C_RDX)) &
                      ((shit & ((sst == L_O) | (sst == L_M))) | wbhit);
  assign snp_data   = !snp_supply ? '0 : (wbhit ? wb_d : dt[sidx]);

  assign cpu_done  = idle_ok & chit & (~cpu_we | (cst == L_E) | (cst == L_M));
  assign cpu_stall = cpu_req & ~cpu_done;
  assign cpu_rdata = (cpu_done & ~cpu_we) ? dt[cidx] : '0;

  assign bus_req   = (fsm == F_ARB);
  assign cur_cmd   = wb_v ? C_WB : pcmd;
  assign bus_cmd   = (bus_req & bus_gnt) ? cur_cmd : 3'd0;
  assign bus_addr  = !bus_req ? '0 : (wb_v ? wb_a : cpu_addr);
  assign bus_wdata = (bus_req & wb_v) ? wb_d : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        st[i] <= L_I; tg[i] <= '0; dt[i] <= '0;
      end
      fsm <= F_IDLE; pcmd <= 3'd0; vidx <= '0; rr <= '0;
      wb_v <= 1'b0; wb_a <= '0; wb_d <= '0; gd <= 1'b0; ga <= 1'b0;
    end else begin
      if (shit) begin
        if (snp_cmd == C_RD) begin
          if (sst == L_M) st[sidx] <= L_O;
          else if (sst == L_E) st[sidx] <= L_S;
        end else if (s_inv) begin
          st[sidx] <= L_I;
        end
      end
      if (wbhit && ((snp_cmd == C_RDX) || (snp_cmd == C_UPG))) wb_v <= 1'b0;
      if (fsm == F_ARB && pcmd == C_UPG && s_inv && sidx == vidx) pcmd <= C_RDX;

      case (fsm)
        F_IDLE: begin
          if (cpu_done && cpu_we) begin
            dt[cidx] <= cpu_wdata;
            st[cidx] <= L_M;
          end else if (idle_ok && !cpu_done) begin
            if (chit) begin
              pcmd <= C_UPG;
              vidx <= cidx;
            end else begin
              pcmd <= cpu_we ? C_RDX : C_RD;
              vidx <= victim;
              if (!(|freev)) rr <= (rr == IW'(LINES-1)) ? '0 : rr + 1'b1;
              if (st[victim] == L_O || st[victim] == L_M) begin
                wb_v <= 1'b1; wb_a <= tg[victim]; wb_d <= dt[victim];
                st[victim] <= L_I;
              end
            end
            fsm <= F_ARB;
          end
        end
        F_ARB: begin
          if (bus_gnt) begin
            if (wb_v) begin
              wb_v <= 1'b0;
            end else begin
              gd <= 1'b0; ga <= 1'b0; fsm <= F_WAIT;
              if (pcmd == C_UPG) st[vidx] <= L_SM;
              else begin
                tg[vidx] <= cpu_addr;
                st[vidx] <= (pcmd == C_RD) ? L_IS : L_IM;
              end
            end
          end
        end
        F_WAIT: begin
          case (st[vidx])
            L_IS: if (rsp_data_valid) begin
              dt[vidx] <= rsp_data;
              st[vidx] <= rsp_shared ? L_S : L_E;
              fsm <= F_IDLE;
            end
            L_IM: begin
              if (rsp_data_valid) begin dt[vidx] <= rsp_data; gd <= 1'b1; end
              if (rsp_acks_done) ga <= 1'b1;
              if ((gd || rsp_data_valid) && (ga || rsp_acks_done)) begin
                st[vidx] <= L_M;
                fsm <= F_IDLE;
              end
            end
            L_SM: if (rsp_acks_done) begin
              st[vidx] <= L_M;
              fsm <= F_IDLE;
            end
            default: fsm <= F_IDLE;
          endcase
        end
        default: fsm <= F_IDLE;
      endcase
    end
  end

  assert_single_copy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmatch));

  assert_im_waits_both_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm == F_WAIT && st[vidx] == L_IM && !(gd || rsp_data_valid)) |=> (fsm == F_WAIT));

  assert_store_dirty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_done && cpu_we) |=> (st[$past(cidx)] == L_M));

  assert_m_to_owned_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (shit && snp_cmd == C_RD && sst == L_M) |=> (st[$past(sidx)] == L_O));

  assert_snoop_invalidates_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (s_inv && fsm != F_WAIT) |=> (st[$past(sidx)] == L_I));

  assert_upgrade_converts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm == F_ARB && !bus_gnt && pcmd == C_UPG && s_inv && sidx == vidx) |=> (pcmd == C_RDX));
endmodule

// File: tb/test_coh_snoop_ctrl.sv
module test_coh_snoop_ctrl;
  localparam int AW = 8, DW = 8, N = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_req = 0, cpu_we = 0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic cpu_done, cpu_stall;
  logic [DW-1:0] cpu_rdata;
  logic bus_req, bus_gnt = 0;
  logic [2:0] bus_cmd;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic rsp_data_valid = 0, rsp_shared = 0, rsp_acks_done = 0;
  logic [DW-1:0] rsp_data = '0;
  logic snp_valid = 0;
  logic [2:0] snp_cmd = '0;
  logic [AW-1:0] snp_addr = '0;
  logic snp_shared, snp_supply;
  logic [DW-1:0] snp_data;

  coh_snoop_ctrl #(.AW(AW), .DW(DW), .LINES(N)) i_coh_snoop_ctrl (.*);

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  string tag = "R1";
  bit gnt_en = 1;
  logic [DW-1:0] ag_data = '0;
  bit ag_shared = 0;
  int ag_dat_at = 1, ag_ack_at = 1;

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // reference model: per-line state codes 0 I,1 S,2 E,3 O,4 M,5 IS,6 IM,7 SM
  int ms [N];
  logic [7:0] mt [N], md [N];
  int mrr, mph, mcmd, mv;
  bit mwb, mgd, mga;
  logic [7:0] mwa, mwd;

  always @(negedge clk) begin
    int ci, si, fi, v;
    bit wh, e_done, e_sup, e_req;
    logic [2:0] cur;
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin ms[i] = 0; mt[i] = 0; md[i] = 0; end
      mrr = 0; mph = 0; mcmd = 0; mv = 0; mwb = 0; mgd = 0; mga = 0; mwa = 0; mwd = 0;
      chk("cpu_done", cpu_done, 0);
      chk("bus_req", bus_req, 0);
      chk("snp_supply", snp_supply, 0);
    end else begin
      ci = -1; si = -1; fi = -1;
      for (int i = 0; i < N; i++) begin
        if (ms[i] >= 1 && ms[i] <= 4 && mt[i] == cpu_addr && ci < 0) ci = i;
        if (ms[i] >= 1 && ms[i] <= 4 && mt[i] == snp_addr && si < 0) si = i;
        if (ms[i] == 0 && fi < 0) fi = i;
      end
      if (!snp_valid) si = -1;
      wh = snp_valid && mwb && mwa == snp_addr;
      e_done = mph == 0 && cpu_req && !snp_valid && ci >= 0 && (!cpu_we || ms[ci] == 2 || ms[ci] == 4);
      e_sup = snp_valid && (snp_cmd == 1 || snp_cmd == 2) && ((si >= 0 && ms[si] >= 3) || wh);
      e_req = mph == 1;
      cur = mwb ? 3'd4 : 3'(mcmd);
      chk("cpu_done", cpu_done, e_done);
      chk("cpu_stall", cpu_stall, cpu_req && !e_done);
      chk("cpu_rdata", cpu_rdata, (e_done && !cpu_we) ? md[ci] : 0);
      chk("bus_req", bus_req, e_req);
      chk("bus_cmd", bus_cmd, (e_req && bus_gnt) ? cur : 0);
      chk("bus_addr", bus_addr, !e_req ? 0 : (mwb ? mwa : cpu_addr));
      chk("bus_wdata", bus_wdata, (e_req && mwb) ? mwd : 0);
      chk("snp_shared", snp_shared, snp_valid && (si >= 0 || wh));
      chk("snp_supply", snp_supply, e_sup);
      chk("snp_data", snp_data, !e_sup ? 0 : (wh ? mwd : md[si]));
      if (si >= 0) begin
        if (snp_cmd == 1) begin
          if (ms[si] == 4) ms[si] = 3; else if (ms[si] == 2) ms[si] = 1;
        end else if (snp_cmd == 2 || snp_cmd == 3) begin
          if (mph == 1 && mcmd == 3 && si == mv) mcmd = 2;
          ms[si] = 0;
        end
      end
      if (wh && (snp_cmd == 2 || snp_cmd == 3)) mwb = 0;
      if (mph == 0) begin
        if (e_done) begin
          if (cpu_we) begin md[ci] = cpu_wdata; ms[ci] = 4; end
        end else if (cpu_req && !snp_valid) begin
          if (ci >= 0) begin mcmd = 3; mv = ci; end
          else begin
            v = (fi >= 0) ? fi : mrr;
            if (fi < 0) mrr = (mrr + 1) % N;
            mcmd = cpu_we ? 2 : 1; mv = v;
            if (ms[v] == 3 || ms[v] == 4) begin mwb = 1; mwa = mt[v]; mwd = md[v]; ms[v] = 0; end
          end
          mph = 1;
        end
      end else if (mph == 1) begin
        if (bus_gnt) begin
          if (mwb) mwb = 0;
          else begin
            mgd = 0; mga = 0; mph = 2;
            if (mcmd == 3) ms[mv] = 7;
            else begin mt[mv] = cpu_addr; ms[mv] = (mcmd == 1) ? 5 : 6; end
          end
        end
      end else begin
        if (ms[mv] == 5) begin
          if (rsp_data_valid) begin md[mv] = rsp_data; ms[mv] = rsp_shared ? 1 : 2; mph = 0; end
        end else if (ms[mv] == 6) begin
          if ((mgd || rsp_data_valid) && (mga || rsp_acks_done)) begin ms[mv] = 4; mph = 0; end
          if (rsp_data_valid) begin md[mv] = rsp_data; mgd = 1; end
          if (rsp_acks_done) mga = 1;
        end else if (ms[mv] == 7) begin
          if (rsp_acks_done) begin ms[mv] = 4; mph = 0; end
        end else mph = 0;
      end
    end
  end

  // bus agent: arbiter grant and responses
  initial begin
    int pend, age;
    pend = 0; age = 0;
    forever begin
      @(posedge clk); #2;
      bus_gnt = 0; rsp_data_valid = 0; rsp_acks_done = 0; rsp_shared = 0; rsp_data = '0;
      if (!rst_n) pend = 0;
      else if (pend != 0) begin
        age++;
        if (pend == 1) begin
          rsp_data_valid = 1; rsp_data = ag_data; rsp_shared = ag_shared; pend = 0;
        end else begin
          if (pend == 2 && age == ag_dat_at) begin rsp_data_valid = 1; rsp_data = ag_data; end
          if (age == ag_ack_at) rsp_acks_done = 1;
          if (age >= ag_ack_at && (pend == 3 || age >= ag_dat_at)) pend = 0;
        end
      end else if (gnt_en && bus_req && !snp_valid) begin
        bus_gnt = 1; #1;
        pend = (bus_cmd == 3'd4) ? 0 : int'(bus_cmd); age = 0;
      end
    end
  end

  task automatic start_op(bit we, logic [7:0] a, logic [7:0] d);
    @(posedge clk); #1;
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
  endtask

  task automatic wait_done();
    int n;
    n = 0;
    do begin @(negedge clk); n++; end while (!cpu_done && n < 300);
    checks++;
    if (!cpu_done) begin fails++; $display("FAIL %s request completion: actual 0 expected 1", tag); end
    @(posedge clk); #1;
    cpu_req = 0; cpu_we = 0;
  endtask

  task automatic cpu_op(bit we, logic [7:0] a, logic [7:0] d);
    start_op(we, a, d);
    wait_done();
  endtask

  task automatic snoop(logic [2:0] c, logic [7:0] a);
    @(posedge clk); #1;
    snp_valid = 1; snp_cmd = c; snp_addr = a;
    @(posedge clk); #1;
    snp_valid = 0; snp_cmd = '0; snp_addr = '0;
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog %s: actual timeout expected completion", tag);
    finish_up();
  end

  initial begin
    tag = "R1";
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    tag = "R3"; ag_data = 8'h11; ag_shared = 0;
    cpu_op(0, 8'h10, 0);
    tag = "R2"; cpu_op(0, 8'h10, 0);
    tag = "R6"; cpu_op(1, 8'h10, 8'hA1);
    tag = "R7"; snoop(3'd1, 8'h10); snoop(3'd1, 8'h10);
    tag = "R3"; ag_data = 8'h22; ag_shared = 1;
    cpu_op(0, 8'h20, 0);
    tag = "R2"; cpu_op(0, 8'h20, 0);
    tag = "R5"; ag_ack_at = 2;
    cpu_op(1, 8'h20, 8'hB2);
    cpu_op(0, 8'h20, 0);
    cpu_op(1, 8'h10, 8'hA2);
    tag = "R4"; ag_data = 8'h33; ag_dat_at = 3; ag_ack_at = 1;
    cpu_op(1, 8'h30, 8'hC3);
    ag_data = 8'h44; ag_dat_at = 1; ag_ack_at = 4;
    cpu_op(1, 8'h40, 8'hD4);
    ag_dat_at = 2; ag_ack_at = 2;
    tag = "R8"; snoop(3'd2, 8'h20);
    tag = "R10"; ag_data = 8'h45; ag_shared = 1;
    cpu_op(0, 8'h20, 0);
    tag = "R8"; snoop(3'd3, 8'h20);
    tag = "R9"; cpu_op(0, 8'h20, 0);
    gnt_en = 0; ag_data = 8'h46; ag_dat_at = 1; ag_ack_at = 1;
    start_op(1, 8'h20, 8'hB9);
    repeat (2) @(posedge clk);
    snoop(3'd3, 8'h20);
    gnt_en = 1;
    wait_done();
    cpu_op(0, 8'h20, 0);
    tag = "R11"; gnt_en = 0; ag_data = 8'h55; ag_shared = 0;
    start_op(0, 8'h50, 0);
    repeat (2) @(posedge clk);
    snoop(3'd1, 8'h10);
    gnt_en = 1;
    tag = "R10"; wait_done();
    tag = "R11"; gnt_en = 0; ag_data = 8'h66;
    start_op(0, 8'h60, 0);
    repeat (2) @(posedge clk);
    snoop(3'd2, 8'h20);
    gnt_en = 1;
    wait_done();
    tag = "R7"; snoop(3'd1, 8'h60);
    tag = "R5"; cpu_op(1, 8'h60, 8'h6F);
    tag = "R12";
    @(posedge clk); #1;
    cpu_req = 1; cpu_we = 0; cpu_addr = 8'h30;
    snp_valid = 1; snp_cmd = 3'd1; snp_addr = 8'h77;
    @(posedge clk); #1;
    snp_valid = 0; snp_cmd = '0; snp_addr = '0;
    wait_done();
    tag = "R2"; cpu_op(0, 8'h40, 0);
    repeat (3) @(posedge clk);
    finish_up();
  end
endmodule